// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

The block keeps a free-running up-counter and a compare register of the same width. When the counter equals the compare value, a timer request is latched and driven onto one of eight interrupt lines, selected by a 3-bit field. The request is level-sensitive. It stays up until software writes the compare register, which is the only way to acknowledge it.

A clock-enable divider turns the system clock into the count tick. With the default ratio of two, a 200 MHz system clock gives one count per 10 ns, which is a 100 MHz time base. A stop input freezes the counter and the divider together and suppresses matching, so counting resumes exactly where it paused. A single write port loads either the counter or the compare register. When the revision-2 mode input is high, a sticky status bit mirrors the latched request.

Top module: `cc_timer`

## Requirements
- R1: After reset, `count_o` is 0, `irq_o` is 0 and `tick_status_o` is 0. The compare register resets to all ones.
- R2: While `stop_i` is low, the counter increases by exactly one every `TICK_DIV` system clocks and by no other amount, unless it is loaded.
- R3: While `stop_i` is high, the counter and the tick divider hold their values. After `stop_i` falls, counting resumes from the held value.
- R4: While `stop_i` is high, equality between counter and compare latches no request.
- R5: A write with `wr_sel_i` = 0 loads `wr_data_i` into the counter on that clock edge. It wins over a tick in the same cycle.
- R6: When counter equals compare and `stop_i` is low, the request is latched on the next clock edge. `irq_o` then has exactly one bit set.
- R7: The request stays asserted after the counter moves past the compare value, until the next compare write.
- R8: `tick_status_o` is set together with the request only when `rev2_i` is high. With `rev2_i` low it stays 0.
- R9: A write with `wr_sel_i` = 1 loads the compare register, clears the request and, when `rev2_i` is high, clears `tick_status_o`. It wins over a match in the same cycle.
- R10: While the request is latched, `irq_o` equals 1 shifted left by `line_sel_i` (0 to 7), and it follows changes of `line_sel_i` combinationally.
- R11: The counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Count disable: freezes counter and divider, suppresses match |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 compare |
| wr_data_i | input | 32 | Write data |
| line_sel_i | input | 3 | Interrupt line selector |
| rev2_i | input | 1 | Revision-2 mode, enables the status bit |
| count_o | output | 32 | Current counter value |
| irq_o | output | 8 | Interrupt line vector |
| tick_status_o | output | 1 | Sticky timer-pending status |

## Verification
The match path is tried in four situations: a counter running up to the compare value, a counter loaded to equal the compare value while stopped, a compare write arriving in the same cycle as an active match, and a counter that has already moved past the compare value. Together these separate a level-sticky request from a pulse, and a write-wins priority from a match-wins one. Counter loads are placed both on a tick cycle and off one, to show whether the load or the increment prevails. The request is raised once with revision-2 mode on and once with it off, which shows whether the status bit is gated by the mode. The wrap is driven from all ones.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic {
    REG_COUNT   = 1'b0,
    REG_COMPARE = 1'b1
  } cct_reg_e;
endpackage

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    div_q <= '0;
        else if (run_i) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end
      assign tick_o = run_i && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  // load wins over tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
  assign count_o = cnt_q;
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] count_i,
  input  logic         run_i,
  output logic         match_o
);
  logic [W-1:0] cmp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= RST_VAL;
    else if (load_i) cmp_q <= load_val_i;
  end
  assign match_o = run_i && (count_i == cmp_q);
endmodule

// File: rtl/cct_irq_ctrl.sv
module cct_irq_ctrl #(
  parameter int unsigned LINES = 8,
  localparam int unsigned SW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_i,
  input  logic             ack_i,
  input  logic             rev2_i,
  input  logic [SW-1:0]    line_sel_i,
  output logic [LINES-1:0] irq_o,
  output logic             status_o
);
  logic pend_q, stat_q;
  // ack (compare write) wins over a match in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (ack_i) begin
      pend_q <= 1'b0;
      if (rev2_i) stat_q <= 1'b0;
    end else if (match_i) begin
      pend_q <= 1'b1;
      if (rev2_i) stat_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_o[i] = pend_q && (line_sel_i == SW'(i));
  end
  assign status_o = stat_q;
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int unsigned W        = 32,
  parameter int unsigned LINES    = 8,
  parameter int unsigned TICK_DIV = 2,
  localparam int unsigned SW      = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [SW-1:0]    line_sel_i,
  input  logic             rev2_i,
  output logic [W-1:0]     count_o,
  output logic [LINES-1:0] irq_o,
  output logic             tick_status_o
);
  import cct_pkg::*;

  logic run, tick, wr_cnt, wr_cmp, match;
  logic [W-1:0] cnt;

  assign run    = !stop_i;
  assign wr_cnt = wr_en_i && (cct_reg_e'(wr_sel_i) == REG_COUNT);
  assign wr_cmp = wr_en_i && (cct_reg_e'(wr_sel_i) == REG_COMPARE);

  cct_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  cct_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .load_i(wr_cnt), .load_val_i(wr_data_i), .count_o(cnt)
  );

  cct_compare #(.W(W), .RST_VAL({W{1'b1}})) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_cmp), .load_val_i(wr_data_i),
    .count_i(cnt), .run_i(run), .match_o(match)
  );

  cct_irq_ctrl #(.LINES(LINES)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .ack_i(wr_cmp),
    .rev2_i(rev2_i), .line_sel_i(line_sel_i), .irq_o(irq_o),
    .status_o(tick_status_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned LINES = 8,
  localparam int unsigned SW   = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [W-1:0]     wr_data_i,
  input logic [SW-1:0]    line_sel_i,
  input logic             rev2_i,
  input logic [W-1:0]     count_o,
  input logic [LINES-1:0] irq_o,
  input logic             tick_status_o
);
  logic wr_cnt, wr_cmp;
  assign wr_cnt = wr_en_i && !wr_sel_i;
  assign wr_cmp = wr_en_i && wr_sel_i;

  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  a_r3_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_cnt) |=> count_o == $past(count_o));

  a_r4_no_match_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|irq_o) |-> !$past(stop_i));

  a_r5_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> count_o == $past(wr_data_i));

  a_r6_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  a_r8_status_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick_status_o) |-> $past(rev2_i));

  a_r9_cmp_wr_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> irq_o == '0);

  a_r9_cmp_wr_clr_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp && rev2_i) |=> !tick_status_o);

  a_r10_line_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> irq_o == (LINES'(1) << line_sel_i));
endmodule

bind cc_timer cc_timer_chk #(.W(W), .LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .line_sel_i(line_sel_i),
  .rev2_i(rev2_i), .count_o(count_o), .irq_o(irq_o),
  .tick_status_o(tick_status_o)
);

// File: tb/cc_timer_test.sv
module cc_timer_test;
  localparam int DIV = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stop_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  line_sel_i = '0;
  logic        rev2_i = 1'b0;
  logic [31:0] count_o;
  logic [7:0]  irq_o;
  logic        tick_status_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  cc_timer #(.TICK_DIV(DIV)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .line_sel_i(line_sel_i),
    .rev2_i(rev2_i), .count_o(count_o), .irq_o(irq_o),
    .tick_status_o(tick_status_o)
  );

  // behavioural reference
  longint m_cnt, m_cmp;
  int     m_div;
  bit     m_pend, m_stat;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_cmp = 64'hFFFF_FFFF; m_div = 0; m_pend = 0; m_stat = 0;
    end else begin
      bit hit, tk;
      hit = !stop_i && (m_cnt == m_cmp);
      tk  = !stop_i && (m_div == DIV - 1);
      if (!stop_i) m_div = (m_div + 1) % DIV;
      if (wr_en_i && !wr_sel_i) m_cnt = wr_data_i;
      else if (tk) m_cnt = (m_cnt + 1) % 64'h1_0000_0000;
      if (wr_en_i && wr_sel_i) begin
        m_cmp = wr_data_i;
        m_pend = 0;
        if (rev2_i) m_stat = 0;
      end else if (hit) begin
        m_pend = 1;
        if (rev2_i) m_stat = 1;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, just after the falling edge
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      check("R2", count_o, m_cnt);
      check("R6", irq_o, m_pend ? (64'd1 << line_sel_i) : 0);
      check("R8", tick_status_o, m_stat);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  initial begin
    step(3);
    #2;
    check("R1", count_o, 0);
    check("R1", irq_o, 0);
    check("R1", tick_status_o, 0);
    rst_ni = 1'b1;

    step(10); #2;
    check("R2", count_o, 5);

    stop_i = 1'b1;
    step(6); #2;
    check("R3", count_o, 5);
    stop_i = 1'b0;
    step(2); #2;
    check("R3", count_o, 6);

    wr(1'b0, 32'd100); #2;
    check("R5", count_o, 100);
    wr(1'b0, 32'd200); #2;            // lands on a tick edge
    check("R5", count_o, 200);

    rev2_i = 1'b1; line_sel_i = 3'd5;
    wr(1'b1, 32'd210);
    step(25); #2;
    check("R6", irq_o, 8'h20);
    check("R8", tick_status_o, 1);
    check("R7", count_o > 210, 1);
    check("R7", irq_o != 0, 1);

    line_sel_i = 3'd2; #2;
    check("R10", irq_o, 8'h04);

    wr(1'b1, 32'hFFFF_0000); #2;
    check("R9", irq_o, 0);
    check("R9", tick_status_o, 0);

    rev2_i = 1'b0;
    wr(1'b0, 32'd300);
    wr(1'b1, 32'd305);
    step(20); #2;
    check("R8", irq_o, 8'h04);
    check("R8", tick_status_o, 0);

    stop_i = 1'b1;
    wr(1'b1, 32'd400);
    wr(1'b0, 32'd400);
    step(10); #2;
    check("R4", irq_o, 0);
    stop_i = 1'b0;
    step(2); #2;
    check("R4", irq_o, 8'h04);

    stop_i = 1'b1;
    wr(1'b0, 32'd500);
    wr(1'b1, 32'd500);
    stop_i = 1'b0;
    wr(1'b1, 32'd500);                // compare write against a live match
    #2;
    check("R9", irq_o, 0);

    rev2_i = 1'b1;
    wr(1'b1, 32'd5);
    wr(1'b0, 32'hFFFF_FFFF);
    step(4); #2;
    check("R11", count_o < 3, 1);
    step(20); #2;
    check("R11", irq_o, 8'h04);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule